// File: doc/BRIEF.md
# Communication Unit Error Interrupt Controller

This block gathers address-miss and protection faults reported by up to eight communication sub-units. Each fault is recorded in a sticky cause register, where every sub-unit has its own four-bit group. A mask register selects which recorded faults drive a single level-sensitive interrupt line. Alongside the cause bits, the block latches the faulting address of the first error it sees. It keeps that address until software reads it back.

Software reaches the block through a plain 32-bit register port with a write strobe, a read strobe and a byte offset. Cause bits are cleared by writing zero to them. The usual handler reads the cause register, writes back the inverse of that value, and then reads the error address to re-arm capture. Each sub-unit drives a fault strobe, a three-bit kind vector and the offending address in the same cycle.

Top module: `cuei_top`

## Requirements
- R1: After reset the cause register, the mask register and the error address all read 0, and `irq` is low.
- R2: A fault from slot s sets cause bit 4*s+k for each kind bit k that is set (k=0 address miss, k=1 access protection, k=2 write protection). Bit 3 of every group always reads 0. The cause register is at offset 0x0.
- R3: Cause bits are sticky. A bit stays 1 until software clears it.
- R4: A write to offset 0x0 clears each cause bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. A write never sets a cause bit.
- R5: When a fault sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: Slots 3 and 6 are reserved (parameter `SLOT_PRESENT` = 8'b1011_0111). Faults signalled on a reserved slot change neither the cause register nor the error address.
- R7: The mask register at offset 0x4 is readable and writable. Only implemented cause positions are stored (bits 0..2 of each present slot), so other bits read 0.
- R8: `irq` is high exactly when some cause bit and its mask bit are both 1. It rises on the clock edge that records the fault and stays high until every unmasked cause bit is cleared or masked.
- R9: The error address register is at offset 0x8. A fault with at least one kind bit set, arriving while no address is held, loads that fault's address. While an address is held, later faults do not overwrite it.
- R10: A read of offset 0x8 releases the hold. If a fault arrives in the same cycle as that read, the new fault's address is captured and held.
- R11: When several slots report faults in the same cycle, the captured address is the one from the lowest-numbered slot.
- R12: Reads of unmapped offsets return 0. Writes to offset 0x8 or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of offset 0x8 releases the address hold) |
| reg_addr | input | AW (4) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset (combinational) |
| ev_valid | input | NUM_SLOTS (8) | Per-slot fault strobe |
| ev_kind | input | 3*NUM_SLOTS (24) | Per-slot fault kind bits, slot s at [3s+2:3s] |
| ev_addr | input | ADDR_W*NUM_SLOTS (256) | Per-slot faulting address, slot s at [ADDR_W*s +: ADDR_W] |
| irq | output | 1 | Level interrupt: OR of cause AND mask |

## Verification
A cause group that dropped a bit or kept a stale bit shows up at the next read of offset 0x0. Because `irq` follows the masked cause with no extra stage, it shows on `irq` in the same cycle as well. A capture hold that was never released, or was released too early, stays hidden until the next fault. After that fault it shows as a wrong error address on the following read. The bench therefore places each hold-sensitive check right after a controlled read and a controlled fault.

// File: rtl/cuei_pkg.sv
package cuei_pkg;

  localparam int GRP_W   = 4;
  localparam int KIND_W  = 3;

  localparam logic [7:0] OFF_CAUSE = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_EADDR = 8'h08;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_EADDR = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    case (off)
      OFF_CAUSE: decode_off = SEL_CAUSE;
      OFF_MASK:  decode_off = SEL_MASK;
      OFF_EADDR: decode_off = SEL_EADDR;
      default:   decode_off = SEL_NONE;
    endcase
  endfunction

  // Expand a fault kind into a cause group; the top bit is reserved.
  function automatic logic [GRP_W-1:0] kind_to_grp(input logic [KIND_W-1:0] k);
    kind_to_grp = {1'b0, k};
  endfunction

  // Implemented cause positions for a slot-present vector.
  function automatic logic [31:0] present_to_valid(input logic [31:0] present,
                                                   input int slots);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < slots; i++) begin
      if (present[i]) m[i*GRP_W +: KIND_W] = '1;
    end
    present_to_valid = m;
  endfunction

endpackage

// File: rtl/cuei_cause_bank.sv
module cuei_cause_bank
  import cuei_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter logic [NUM_SLOTS-1:0] SLOT_PRESENT = 8'b1011_0111,
  localparam int CW = NUM_SLOTS * GRP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        ev_valid,
  input  logic [NUM_SLOTS*KIND_W-1:0] ev_kind,
  input  logic                        clr_en,
  input  logic [CW-1:0]               clr_keep,
  output logic [CW-1:0]               cause,
  output logic [CW-1:0]               set_vec,
  output logic [NUM_SLOTS-1:0]        slot_hit
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [GRP_W-1:0] grp_q;
    logic [GRP_W-1:0] grp_set;
    logic [GRP_W-1:0] grp_kept;

    if (SLOT_PRESENT[s]) begin : g_live
      assign grp_set = ev_valid[s] ? kind_to_grp(ev_kind[s*KIND_W +: KIND_W]) : '0;
    end else begin : g_rsvd
      assign grp_set = '0;
    end

    assign grp_kept = clr_en ? (grp_q & clr_keep[s*GRP_W +: GRP_W]) : grp_q;

    always_ff @(posedge clk) begin
      if (!rst_n) grp_q <= '0;
      else        grp_q <= grp_kept | grp_set;
    end

    assign cause[s*GRP_W +: GRP_W]   = grp_q;
    assign set_vec[s*GRP_W +: GRP_W] = grp_set;
    assign slot_hit[s]               = |grp_set;
  end

endmodule

// File: rtl/cuei_addr_capture.sv
module cuei_addr_capture #(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        slot_hit,
  input  logic [NUM_SLOTS*ADDR_W-1:0] ev_addr,
  input  logic                        release_rd,
  output logic [ADDR_W-1:0]           addr_q,
  output logic                        held,
  output logic                        capture
);

  logic [ADDR_W-1:0] pick;

  // Lowest-numbered slot wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_hit[i]) pick = ev_addr[i*ADDR_W +: ADDR_W];
    end
  end

  assign capture = (|slot_hit) && (!held || release_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      held   <= 1'b0;
    end else begin
      if (capture) begin
        addr_q <= pick;
        held   <= 1'b1;
      end else if (release_rd) begin
        held   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cuei_regif.sv
module cuei_regif
  import cuei_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int CW     = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     cause,
  input  logic [ADDR_W-1:0] eaddr,
  input  logic [CW-1:0]     valid_mask,
  output logic              clr_en,
  output logic [CW-1:0]     clr_keep,
  output logic              eaddr_rd,
  output logic [CW-1:0]     mask_q,
  output logic [DW-1:0]     rdata
);

  reg_sel_e sel;

  assign sel      = decode_off(8'(addr));
  assign clr_en   = wr && (sel == SEL_CAUSE);
  assign clr_keep = wdata[CW-1:0];
  assign eaddr_rd = rd && (sel == SEL_EADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)                      mask_q <= '0;
    else if (wr && sel == SEL_MASK)  mask_q <= wdata[CW-1:0] & valid_mask;
  end

  always_comb begin
    case (sel)
      SEL_CAUSE: rdata = DW'(cause);
      SEL_MASK:  rdata = DW'(mask_q);
      SEL_EADDR: rdata = DW'(eaddr);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/cuei_top.sv
module cuei_top
  import cuei_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 32,
  parameter int AW        = 4,
  parameter logic [NUM_SLOTS-1:0] SLOT_PRESENT = 8'b1011_0111,
  localparam int DW = 32,
  localparam int CW = NUM_SLOTS * GRP_W,
  localparam logic [CW-1:0] VALID_MASK =
    CW'(present_to_valid(32'(SLOT_PRESENT), NUM_SLOTS))
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [AW-1:0]               reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  output logic [DW-1:0]               reg_rdata,
  input  logic [NUM_SLOTS-1:0]        ev_valid,
  input  logic [NUM_SLOTS*KIND_W-1:0] ev_kind,
  input  logic [NUM_SLOTS*ADDR_W-1:0] ev_addr,
  output logic                        irq
);

  logic [CW-1:0]        cause_q;
  logic [CW-1:0]        set_vec;
  logic [CW-1:0]        mask_q;
  logic [CW-1:0]        clr_keep;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 clr_en;
  logic                 eaddr_rd;
  logic                 held;
  logic                 capture;
  logic [ADDR_W-1:0]    eaddr_q;

  cuei_cause_bank #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_PRESENT(SLOT_PRESENT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .clr_en(clr_en), .clr_keep(clr_keep), .cause(cause_q),
    .set_vec(set_vec), .slot_hit(slot_hit)
  );

  cuei_addr_capture #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .slot_hit(slot_hit), .ev_addr(ev_addr),
    .release_rd(eaddr_rd), .addr_q(eaddr_q), .held(held), .capture(capture)
  );

  cuei_regif #(
    .AW(AW), .DW(DW), .CW(CW), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cause(cause_q), .eaddr(eaddr_q),
    .valid_mask(VALID_MASK), .clr_en(clr_en), .clr_keep(clr_keep),
    .eaddr_rd(eaddr_rd), .mask_q(mask_q), .rdata(reg_rdata)
  );

  assign irq = |(cause_q & mask_q);

endmodule

// File: rtl/cuei_chk.sv
module cuei_chk #(
  parameter int CW     = 32,
  parameter int ADDR_W = 32,
  parameter logic [CW-1:0] VALID = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              irq,
  input logic [CW-1:0]     cause,
  input logic [CW-1:0]     mask,
  input logic [CW-1:0]     set_vec,
  input logic              clr_en,
  input logic              held,
  input logic              eaddr_rd,
  input logic [ADDR_W-1:0] eaddr_q
);

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~VALID) == '0);  // R2
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((cause & $past(cause)) == $past(cause)));  // R3
  AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_vec == '0) |=> ((cause & ~$past(cause)) == '0));  // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));  // R5
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~VALID) == '0);  // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);  // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !eaddr_rd) |=> $stable(eaddr_q));  // R9

endmodule

bind cuei_top cuei_chk #(.CW(CW), .ADDR_W(ADDR_W), .VALID(VALID_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .irq(irq), .cause(cause_q),
  .mask(mask_q), .set_vec(set_vec), .clr_en(clr_en), .held(held),
  .eaddr_rd(eaddr_rd), .eaddr_q(eaddr_q)
);

// File: tb/sim_cuei_top.sv
module sim_cuei_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int AWID = 32;
  localparam logic [31:0] EXP_VALID = 32'h7077_0777;  // slots 0,1,2,4,5,7

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [3:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NS-1:0]     ev_valid = '0;
  logic [NS*3-1:0]   ev_kind = '0;
  logic [NS*AWID-1:0] ev_addr = '0;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  cuei_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = off;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic put_ev(input int s, input logic [2:0] k, input logic [31:0] a);
    ev_valid[s] = 1'b1;
    ev_kind[s*3 +: 3] = k;
    ev_addr[s*AWID +: AWID] = a;
  endtask

  task automatic fire(input int s, input logic [2:0] k, input logic [31:0] a);
    @(negedge clk);
    put_ev(s, k, a);
    @(negedge clk);
    ev_valid = '0; ev_kind = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); check("R1 cause", d, 0);
    rd(4'h4, d); check("R1 mask", d, 0);
    rd(4'h8, d); check("R1 eaddr", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    fire(2, 3'b101, 32'hA000_0010);
    fire(5, 3'b010, 32'hB000_0020);
    rd(4'h0, d); check("R2 R3 cause groups", d, 32'h0020_0500);
    check("R8 irq masked off", {31'b0, irq}, 0);
    rd(4'h8, d); check("R9 first address kept", d, 32'hA000_0010);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(4'h0, ~32'h0000_0500);
    rd(4'h0, d); check("R4 clear by zero", d, 32'h0020_0000);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R4 ones keep, never set", d, 32'h0020_0000);
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R4 full clear", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R7 mask implemented bits", d, EXP_VALID);
    fire(1, 3'b001, 32'hC000_0030);
    check("R8 irq rises", {31'b0, irq}, 1);
    wr(4'h4, 32'h0);
    check("R8 irq masked", {31'b0, irq}, 0);
    wr(4'h4, 32'h0000_0010);
    check("R8 irq unmasked again", {31'b0, irq}, 1);
    wr(4'h0, 32'h0);
    check("R8 irq drops after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    rd(4'h8, d); check("R9 address of slot 1", d, 32'hC000_0030);
    fire(3, 3'b111, 32'hD000_0003);
    fire(6, 3'b111, 32'hD000_0006);
    rd(4'h0, d); check("R6 reserved slots no cause", d, 0);
    rd(4'h8, d); check("R6 reserved slots no capture", d, 32'hC000_0030);
  endtask

  task automatic t_release();
    logic [31:0] d;
    fire(4, 3'b100, 32'hE000_0040);
    rd(4'h8, d); check("R10 capture after release", d, 32'hE000_0040);
    fire(4, 3'b100, 32'hE000_0041);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'h8;
    put_ev(0, 3'b001, 32'hF000_0050);
    #1 check("R10 read returns held value", reg_rdata, 32'hE000_0041);
    @(negedge clk);
    reg_rd = 1'b0; ev_valid = '0; ev_kind = '0;
    rd(4'h8, d); check("R10 same-cycle fault captured", d, 32'hF000_0050);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk);
    put_ev(5, 3'b001, 32'h1111_0005);
    put_ev(1, 3'b100, 32'h2222_0001);
    @(negedge clk);
    ev_valid = '0; ev_kind = '0;
    rd(4'h8, d); check("R11 lowest slot address", d, 32'h2222_0001);
    rd(4'h0, d); check("R11 R2 both groups", d, 32'h0010_0040);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    fire(2, 3'b010, 32'h3333_0002);
    fire(0, 3'b001, 32'h3333_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0;
    put_ev(0, 3'b001, 32'h3333_0000);
    @(negedge clk);
    reg_wr = 1'b0; ev_valid = '0; ev_kind = '0;
    rd(4'h0, d); check("R5 set beats clear", d, 32'h0000_0001);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(4'h8, d);  // release any hold, value now 0x3333_0002
    rd(4'hC, d); check("R12 unmapped read", d, 0);
    wr(4'h8, 32'hDEAD_BEEF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h8, d); check("R12 eaddr not writable", d, 32'h3333_0002);
    rd(4'h4, d); check("R12 mask untouched", d, 32'h0000_0010);
    rd(4'h0, d); check("R12 cause untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_clear();
    t_mask();
    t_reserved();
    t_release();
    t_priority();
    t_setwins();
    t_unmapped();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule